// File: doc/BRIEF.md
# Configuration Region Mapping Decoder

This block turns the programmed state of a device's address windows into live mappings. It reads the command register, six base address registers and the expansion ROM register. Each of the seven regions has a fixed power-of-two size and a fixed space type, set at build time. For every region it registers two results: whether the region is currently mapped, and the aligned base it occupies. It also decodes a looked-up address into the region that claims it.

A region is mapped only when all of the following hold:
- its address space is enabled in the command register;
- its aligned range is legal;
- for the ROM region, the register's own enable bit is set.

The mapping is not recomputed on every cycle. It is recomputed only when a base address register changes or when one of the two space-enable bits in the command register changes. Whenever a recomputation changes a region's result, that region raises a one-cycle notification. The notification lets surrounding logic rebuild its address routing.

Top module: `pci_region_map`

## Requirements
- R1: While reset is held and on the first cycle after it, every `map_valid` bit is 0, every `map_notify` bit is 0 and `lk_hit` is 0.
- R2: A mapped region reports in `map_base` its register value with the low log2(size) bits cleared. An unmapped region reports valid 0 and base 0. Results appear on the clock edge that follows the input change.
- R3: I/O regions (BAR0 and BAR4 in the default build) can map only while command bit 0 is 1. Memory regions, including the ROM, can map only while command bit 1 is 1.
- R4: The ROM region (index 6) can map only while bit 0 of `cfg_rom` is 1.
- R5: An I/O region is unmapped when any of these holds:
  - its aligned base is 0;
  - base+size-1 is not above the base;
  - base+size-1 is 0x10000 or more.
- R6: A memory region is unmapped when any of these holds:
  - its aligned base is 0;
  - base+size-1 is not above the base;
  - base+size-1 equals 0xFFFFFFFF.
- R7: On a clock edge, the mapping is recomputed only if `cfg_bars` or command bits [1:0] differ from their values at the previous edge. A change to `cfg_rom` alone, or to command bits [15:2] alone, leaves every mapping unchanged.
- R8: On a recomputation, `map_notify[i]` pulses for one cycle exactly when region i's (valid, base) pair differs from its previous value. A recomputation that yields the same pair gives no pulse.
- R9: `lk_hit` is 1 when a mapped region contains `lk_addr` inclusively and has the requested space (`lk_io` = 1 selects I/O, 0 selects memory). `lk_idx` then gives the lowest such region index.
- R10: A region of size zero never maps, never hits and never notifies, whatever its register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cmd | input | 16 | Command register; bit 0 enables I/O space, bit 1 enables memory space |
| cfg_bars | input | 192 | Six base address registers, region i in bits [32i+31:32i] |
| cfg_rom | input | 32 | Expansion ROM register; bit 0 is its enable |
| lk_addr | input | 32 | Address to decode |
| lk_io | input | 1 | Space of the lookup: 1 for I/O, 0 for memory |
| lk_hit | output | 1 | A mapped region of that space contains the address |
| lk_idx | output | 3 | Lowest matching region index |
| map_valid | output | 7 | Per-region mapped flag |
| map_base | output | 224 | Per-region aligned base, region i in bits [32i+31:32i] |
| map_notify | output | 7 | Per-region one-cycle pulse on a changed mapping |

## Verification
The hardest case to reach is the ROM mapping being stale. Setting the ROM enable bit, or changing command bits above bit 1, must not recompute anything. The new ROM state takes effect only when a base address register or a space-enable bit later moves. The stimulus reaches this with a chain of single changes: it first alters only the ROM register, then only an upper command bit, and then one base address register byte. It checks the ROM mapping after every step. The same style of stimulus changes only the low, masked bits of a register, which forces a recomputation whose result must produce no notification. Sweeps of boundary base values under all four enable combinations drive the I/O and memory range limits.

// File: rtl/pci_region_pkg.sv
package pci_region_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned CMD_W  = 16;
  localparam logic [ADDR_W-1:0] IO_LIMIT = 32'h0001_0000;

  typedef struct packed {
    logic              ok;
    logic [ADDR_W-1:0] base;
  } rmap_t;

  // Clear the bits covered by a power-of-two size.
  function automatic logic [ADDR_W-1:0] align_base(logic [ADDR_W-1:0] raw,
                                                   logic [ADDR_W-1:0] size);
    return raw & ~(size - 1'b1);
  endfunction

  // Legality of an aligned window.
  function automatic logic range_ok(logic [ADDR_W-1:0] base,
                                    logic [ADDR_W-1:0] size, logic is_io);
    logic [ADDR_W-1:0] last;
    last = base + size - 1'b1;
    if (size == '0 || base == '0 || last <= base) return 1'b0;
    if (is_io) return last < IO_LIMIT;
    return last != '1;
  endfunction

  function automatic logic in_window(logic [ADDR_W-1:0] addr,
                                     logic [ADDR_W-1:0] base,
                                     logic [ADDR_W-1:0] size);
    return (addr >= base) && ((addr - base) < size);
  endfunction
endpackage

// File: rtl/pci_region_eval.sv
module pci_region_eval
  import pci_region_pkg::*;
#(
  parameter int NBAR = 6,
  parameter logic [(NBAR+1)*ADDR_W-1:0] REG_SIZES = '0,
  parameter logic [NBAR-1:0] REG_IO = '0
) (
  input  logic                   io_en,
  input  logic                   mem_en,
  input  logic [NBAR*ADDR_W-1:0] bars,
  input  logic [ADDR_W-1:0]      rom,
  output rmap_t [NBAR:0]         nxt
);
  for (genvar g = 0; g <= NBAR; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] SZ = REG_SIZES[g*ADDR_W +: ADDR_W];
    if (SZ == '0) begin : g_absent
      if (g < NBAR) begin : g_sink
        logic unused_raw;
        assign unused_raw = ^bars[g*ADDR_W +: ADDR_W];
      end
      assign nxt[g] = rmap_t'('0);
    end else begin : g_live
      logic [ADDR_W-1:0] raw, aligned;
      logic is_io, gate, space_on, live;
      if (g == NBAR) begin : g_rom
        assign raw   = rom;
        assign is_io = 1'b0;
        assign gate  = rom[0];
      end else begin : g_bar
        assign raw   = bars[g*ADDR_W +: ADDR_W];
        assign is_io = REG_IO[g];
        assign gate  = 1'b1;
      end
      assign space_on = is_io ? io_en : mem_en;
      assign aligned  = align_base(raw, SZ);
      assign live     = space_on & gate & range_ok(aligned, SZ, is_io);
      assign nxt[g]   = live ? rmap_t'{ok: 1'b1, base: aligned} : rmap_t'('0);
    end
  end
endmodule

// File: rtl/pci_region_watch.sv
module pci_region_watch
  import pci_region_pkg::*;
#(
  parameter int NBAR = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NBAR*ADDR_W-1:0] bars,
  input  logic                   io_en,
  input  logic                   mem_en,
  output logic                   reeval
);
  logic [NBAR*ADDR_W-1:0] prev_bars;
  logic [1:0]             prev_en;

  assign reeval = (bars != prev_bars) || ({mem_en, io_en} != prev_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_bars <= '0;
      prev_en   <= '0;
    end else begin
      prev_bars <= bars;
      prev_en   <= {mem_en, io_en};
    end
  end

  // R7: with inputs held for a cycle, no recomputation is requested
  a_r7_quiet_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(bars) && $stable(io_en) && $stable(mem_en) && $past(rst_n)) |-> !reeval);
endmodule

// File: rtl/pci_region_lookup.sv
module pci_region_lookup
  import pci_region_pkg::*;
#(
  parameter int NBAR = 6,
  parameter logic [(NBAR+1)*ADDR_W-1:0] REG_SIZES = '0,
  parameter logic [NBAR-1:0] REG_IO = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  rmap_t [NBAR:0]              map,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        is_io,
  output logic                        hit,
  output logic [$clog2(NBAR+1)-1:0]   idx
);
  localparam int NREG = NBAR + 1;
  localparam int IW   = $clog2(NREG);

  logic [NREG-1:0] match, below;

  for (genvar g = 0; g < NREG; g++) begin : g_m
    localparam logic [ADDR_W-1:0] SZ = REG_SIZES[g*ADDR_W +: ADDR_W];
    localparam logic TIO = (g < NBAR) ? REG_IO[g % NBAR] : 1'b0;
    assign match[g] = map[g].ok && (TIO == is_io) && in_window(addr, map[g].base, SZ);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

  assign below = match & ((NREG'(1) << idx) - NREG'(1));

  // R9: a hit always names a mapped region
  a_r9_hit_is_mapped: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> map[idx].ok);
  // R9: no lower region also claims the address
  a_r9_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (below == '0));
endmodule

// File: rtl/pci_region_map.sv
module pci_region_map
  import pci_region_pkg::*;
#(
  parameter int NBAR = 6,
  parameter logic [(NBAR+1)*ADDR_W-1:0] REG_SIZES =
    {32'h0000_0800, 32'h0001_0000, 32'h0000_0004, 32'h0000_0000,
     32'h0000_0100, 32'h0000_1000, 32'h0000_0010},
  parameter logic [NBAR-1:0] REG_IO = 6'b01_0001
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CMD_W-1:0]             cfg_cmd,
  input  logic [NBAR*ADDR_W-1:0]       cfg_bars,
  input  logic [ADDR_W-1:0]            cfg_rom,
  input  logic [ADDR_W-1:0]            lk_addr,
  input  logic                         lk_io,
  output logic                         lk_hit,
  output logic [$clog2(NBAR+1)-1:0]    lk_idx,
  output logic [NBAR:0]                map_valid,
  output logic [(NBAR+1)*ADDR_W-1:0]   map_base,
  output logic [NBAR:0]                map_notify
);
  localparam int NREG = NBAR + 1;

  logic  io_en, mem_en, reeval;
  logic  unused_cmd;
  rmap_t [NREG-1:0] nxt, map_q;
  logic  [NREG-1:0] notify_q;

  assign io_en      = cfg_cmd[0];
  assign mem_en     = cfg_cmd[1];
  assign unused_cmd = ^cfg_cmd[CMD_W-1:2];

  pci_region_eval #(.NBAR(NBAR), .REG_SIZES(REG_SIZES), .REG_IO(REG_IO)) u_eval (
    .io_en(io_en), .mem_en(mem_en), .bars(cfg_bars), .rom(cfg_rom), .nxt(nxt));

  pci_region_watch #(.NBAR(NBAR)) u_watch (
    .clk(clk), .rst_n(rst_n), .bars(cfg_bars), .io_en(io_en), .mem_en(mem_en),
    .reeval(reeval));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q    <= '0;
      notify_q <= '0;
    end else if (reeval) begin
      for (int i = 0; i < NREG; i++) notify_q[i] <= (nxt[i] != map_q[i]);
      map_q <= nxt;
    end else begin
      notify_q <= '0;
    end
  end

  pci_region_lookup #(.NBAR(NBAR), .REG_SIZES(REG_SIZES), .REG_IO(REG_IO)) u_look (
    .clk(clk), .rst_n(rst_n), .map(map_q), .addr(lk_addr), .is_io(lk_io),
    .hit(lk_hit), .idx(lk_idx));

  assign map_notify = notify_q;

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign map_valid[g]                 = map_q[g].ok;
    assign map_base[g*ADDR_W +: ADDR_W] = map_q[g].base;

    // R8: a pulse marks a real change of the region's result
    a_r8_notify_real_change: assert property (@(posedge clk) disable iff (!rst_n)
      map_notify[g] |-> ((map_valid[g] != $past(map_valid[g])) ||
                         (map_base[g*ADDR_W +: ADDR_W] != $past(map_base[g*ADDR_W +: ADDR_W]))));

    if (REG_SIZES[g*ADDR_W +: ADDR_W] == '0) begin : g_absent
      // R10: absent region stays silent
      a_r10_absent_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !map_valid[g] && !map_notify[g]);
    end
  end

  // R8: pulses only follow a recomputation
  a_r8_notify_after_reeval: assert property (@(posedge clk) disable iff (!rst_n)
    (|map_notify) |-> $past(reeval));
  // R7: without recomputation the mapping holds
  a_r7_hold_without_reeval: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reeval) |-> ($stable(map_valid) && $stable(map_base)));
endmodule

// File: tb/tb_pci_region_map.sv
`timescale 1ns/1ps
module tb_pci_region_map;
  localparam longint SZ [7] = '{64'd16, 64'd4096, 64'd256, 64'd0, 64'd4, 64'd65536, 64'd2048};
  localparam logic [5:0] ISIO = 6'b01_0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0]  cfg_cmd = '0;
  logic [191:0] cfg_bars = '0;
  logic [31:0]  cfg_rom = '0, lk_addr = '0;
  logic         lk_io = 1'b0, lk_hit;
  logic [2:0]   lk_idx;
  logic [6:0]   map_valid, map_notify;
  logic [223:0] map_base;

  always #4 clk = ~clk;

  pci_region_map #(
    .NBAR(6),
    .REG_SIZES({32'd2048, 32'd65536, 32'd4, 32'd0, 32'd256, 32'd4096, 32'd16}),
    .REG_IO(ISIO)
  ) dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [31:0] bb [6];
  logic [31:0] brom;
  logic [15:0] bcmd;
  logic [31:0] mprev [6];
  logic [1:0]  mpen;
  logic        m_ok [7];
  logic [31:0] m_base [7];
  logic        m_not [7];

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic is_io_reg(int r);
    return (r < 6) ? ISIO[r] : 1'b0;
  endfunction

  function automatic logic want_ok(int r, logic [31:0] raw, logic [15:0] c);
    longint s, b, e;
    logic io;
    s = SZ[r];
    if (s == 0) return 1'b0;
    io = is_io_reg(r);
    if (io ? !c[0] : !c[1]) return 1'b0;
    if (r == 6 && !raw[0]) return 1'b0;
    b = longint'(raw) - (longint'(raw) % s);
    e = b + s - 1;
    if (b == 0 || s < 2) return 1'b0;
    if (io) return e < 65536;
    return e < 64'hFFFF_FFFF;
  endfunction

  task automatic apply(input string tag);
    logic trig, ok;
    logic [31:0] raw, nb;
    @(negedge clk);
    for (int r = 0; r < 6; r++) cfg_bars[r*32 +: 32] = bb[r];
    cfg_rom = brom;
    cfg_cmd = bcmd;
    @(posedge clk);
    trig = (bcmd[1:0] != mpen);
    for (int r = 0; r < 6; r++) if (bb[r] != mprev[r]) trig = 1'b1;
    for (int r = 0; r < 7; r++) begin
      raw = (r == 6) ? brom : bb[r];
      ok  = want_ok(r, raw, bcmd);
      nb  = ok ? 32'(longint'(raw) - (longint'(raw) % SZ[r])) : 32'd0;
      if (trig) begin
        m_not[r]  = (ok != m_ok[r]) || (nb != m_base[r]);
        m_ok[r]   = ok;
        m_base[r] = nb;
      end else m_not[r] = 1'b0;
    end
    for (int r = 0; r < 6; r++) mprev[r] = bb[r];
    mpen = bcmd[1:0];
    @(negedge clk);
    for (int r = 0; r < 7; r++) begin
      check($sformatf("%s valid region %0d", tag, r), map_valid[r], m_ok[r]);
      check($sformatf("R2 base region %0d (%s)", r, tag), map_base[r*32 +: 32], m_base[r]);
      check($sformatf("R8 notify region %0d (%s)", r, tag), map_notify[r], m_not[r]);
    end
  endtask

  task automatic look(input logic [31:0] a, input logic io);
    logic eh;
    int ei;
    @(negedge clk);
    lk_addr = a;
    lk_io   = io;
    #1;
    eh = 1'b0;
    ei = 0;
    for (int r = 0; r < 7; r++)
      if (!eh && m_ok[r] && is_io_reg(r) == io &&
          longint'(a) >= longint'(m_base[r]) &&
          longint'(a) <= longint'(m_base[r]) + SZ[r] - 1) begin
        eh = 1'b1;
        ei = r;
      end
    check($sformatf("R9 hit addr %h io %0d", a, io), lk_hit, eh);
    if (eh) check($sformatf("R9 index addr %h", a), lk_idx, ei);
  endtask

  logic [31:0] sweep [8] = '{32'h0000_0000, 32'h0000_0014, 32'h0000_FFF0, 32'h0001_0000,
                             32'h0000_FFFD, 32'hFFFF_0000, 32'h8000_0101, 32'hFFFF_F801};

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int r = 0; r < 6; r++) begin bb[r] = '0; mprev[r] = '0; end
    for (int r = 0; r < 7; r++) begin m_ok[r] = 0; m_base[r] = 0; m_not[r] = 0; end
    brom = '0; bcmd = '0; mpen = '0;
    repeat (3) @(negedge clk);
    check("R1 valid during reset", map_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", map_valid, 0);
    check("R1 notify after reset", map_notify, 0);
    lk_addr = 32'h1000; lk_io = 1'b1; #1;
    check("R1 no hit after reset", lk_hit, 0);

    bb = '{32'h0000_1000, 32'h8000_0000, 32'h8000_0100, 32'h8000_0000, 32'h0000_1008, 32'h9000_0000};
    brom = 32'hA000_0000;
    bcmd = 16'h0000; apply("R3 both off");
    bcmd = 16'h0001; apply("R3 io only");
    bcmd = 16'h0002; apply("R3 mem only");
    bcmd = 16'h0003; apply("R3 both on");
    apply("R8 held inputs");
    bb[1] = 32'h8000_0ABC; apply("R8 masked bits only");
    brom = 32'hA000_0001; apply("R7 rom change only");
    bcmd = 16'h0007; apply("R7 upper cmd bit only");
    bb[5] = 32'h9001_0000; apply("R4 rom enable seen");
    brom = 32'hA000_0000; bcmd = 16'h0003; apply("R7 rom disable pending");
    bb[5] = 32'h9000_0000; apply("R4 rom disable seen");
    brom = 32'hA000_0001; bb[3] = 32'h1234_5678; apply("R10 absent register written");
    bb[3] = 32'h8000_0000; apply("R10 absent register restored");

    for (int r = 0; r < 7; r++)
      for (int io = 0; io < 2; io++) begin
        longint b;
        b = (r == 6) ? longint'(brom & 32'hFFFF_F800) : longint'(m_base[r]);
        if (!m_ok[r]) b = longint'((r == 6) ? brom : bb[r]);
        look(32'(b - 1), io[0]);
        look(32'(b), io[0]);
        look(32'(b + SZ[r] - 1), io[0]);
        look(32'(b + SZ[r]), io[0]);
      end

    for (int c = 0; c < 4; c++)
      for (int vi = 0; vi < 8; vi++) begin
        for (int r = 0; r < 6; r++) bb[r] = sweep[(vi + r) % 8] + 32'(r * 16'h1000);
        brom = sweep[(vi + 3) % 8] | 32'(vi & 1);
        bcmd = 16'(c);
        apply((c == 1) ? "R5 io sweep" : "R6 mem sweep");
        look(bb[0] + 32'd4, 1'b1);
        look(bb[1] + 32'd4, 1'b0);
      end

    bb[0] = 32'h0000_FFF0; bb[4] = 32'h0000_FFFC; bcmd = 16'h0001; apply("R5 io top of window");
    bb[0] = 32'h0001_0000; bb[4] = 32'h0000_0000; apply("R5 io past window");
    bb[1] = 32'hFFFF_F000; bb[5] = 32'hFFFE_0000; bcmd = 16'h0003; apply("R6 mem end all ones");
    bb[1] = 32'hFFFF_E000; apply("R6 mem just below top");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule